// File: doc/BRIEF.md
# Key-Unlocked Configuration Port

This block is the host-facing configuration window of a legacy-style peripheral controller. It sits on a byte-wide I/O bus and uses two ports. The index port is at the base address and selects a register. The data port is at base+1 and reads or writes the register that the index names. A select input, `host_addr`, picks between the two ports: 0 is the index port and 1 is the data port.

The register space stays closed after reset. It opens only when the unlock key is written to the index port twice in a row. A separate lock key, also written to the index port, closes it again. Once the space is open, global registers give a device ID, a revision and a fixed manufacturer ID. A logical-device select register picks one of `NUM_LD` banks, and indexes 0x30 and above reach the selected bank. Each bank holds an enable bit and a 16-bit base address inside this block. Every other bank index goes out on a simple strobe-style register bus, so the logical device itself can serve it.

Host reads are combinational. `host_rdata` shows the addressed register in the same cycle as `host_rd`. Writes take effect at the next rising clock edge.

Top module: `cfg_key_port`

## Requirements
- R1: After reset, the space is locked, the index register is 0x00 and the logical-device select is 0x00. Every device's enable bit and 16-bit base are also 0.
- R2: The space opens only after two consecutive index-port writes of 0x87. The second of those writes does not load the index register.
- R3: While the space is locked, an index-port write of any value other than 0x87 returns the unlock sequence to idle, so a 0x87 followed by any other byte does not open it. Data-port accesses do not break the sequence.
- R4: While the space is locked, data-port writes change no register and raise no device strobe. Index-port writes leave the index register unchanged. Reads from either port return 0xFF.
- R5: While the space is open, an index-port write of 0xAA locks it. The index register keeps its previous value.
- R6: While the space is open, any other index-port write loads the index register. Reads of the index port return that value.
- R7: Index 0x20 reads the device ID high byte and 0x21 its low byte. Index 0x22 reads the revision. Index 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these indexes have no effect.
- R8: Index 0x07 is the read/write logical-device select. Its full byte chooses the bank that indexes 0x30 and above address.
- R9: In the selected bank, bit 0 of index 0x30 is that device's enable. It drives bit n of `ld_enable` for device n, and bits 7:1 read 0.
- R10: In the selected bank, index 0x60 holds the high byte and 0x61 the low byte of the device base. Device n's base appears on `ld_base[16n+15:16n]`.
- R11: An open data-port access to a bank index other than 0x30, 0x60 or 0x61 raises `dev_wr` or `dev_rd` for one cycle. During that cycle `dev_ld` carries the select, `dev_idx` the index and `dev_wdata` the data, and a read returns `dev_rdata`.
- R12: If the select is `NUM_LD` or more, bank indexes read 0xFF, bank writes have no effect and no device strobe is raised.
- R13: Global indexes below 0x30 other than 0x07 and 0x20 through 0x24 read 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 1 | Port select: 0 index port, 1 data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| ld_enable | output | NUM_LD | Per-device enable bits |
| ld_base | output | 16*NUM_LD | Per-device base addresses, device n at bits 16n+15:16n |
| dev_ld | output | 8 | Logical-device select for the register bus |
| dev_idx | output | 8 | Register index for the register bus |
| dev_wdata | output | 8 | Write data for the register bus |
| dev_wr | output | 1 | Register-bus write strobe |
| dev_rd | output | 1 | Register-bus read strobe |
| dev_rdata | input | 8 | Read data returned by the selected device |

## Verification
The assertions check the locked-state rules on every cycle:
- locked reads return 0xFF;
- no device strobe is raised while locked;
- the index register, enables and bases are frozen while locked;
- the lock key closes the space;
- opening is always preceded by a key write;
- the manufacturer ID reads correctly.

Some behaviour depends on ordering, and only the bench scenarios can show it. This covers an interrupted key sequence that still opens on a later pair of keys, and bank isolation when the select changes. It also covers forwarding to the register bus, an out-of-range select, and the index surviving a relock. Those scenarios are compared against the reference model on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] IDX_LD_SELECT = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI  = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO  = 8'h21;
  localparam logic [7:0] IDX_REVISION  = 8'h22;
  localparam logic [7:0] IDX_MFG_HI    = 8'h23;
  localparam logic [7:0] IDX_MFG_LO    = 8'h24;
  localparam logic [7:0] IDX_BANK_BASE = 8'h30;
  localparam logic [7:0] IDX_LD_ENABLE = 8'h30;
  localparam logic [7:0] IDX_IOBASE_HI = 8'h60;
  localparam logic [7:0] IDX_IOBASE_LO = 8'h61;

  typedef struct packed {
    logic sel_wr;
    logic en_wr;
    logic hi_wr;
    logic lo_wr;
  } bank_wr_t;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       idx_ld
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (idx_wr && wdata == UNLOCK_KEY) state_d = KS_ARMED;
      KS_ARMED:  if (idx_wr) state_d = (wdata == UNLOCK_KEY) ? KS_OPEN : KS_LOCKED;
      KS_OPEN:   if (idx_wr && wdata == LOCK_KEY) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);
  assign idx_ld = open_o && idx_wr && (wdata != LOCK_KEY);
endmodule

// File: rtl/cfg_ld_bank.sv
module cfg_ld_bank #(
  parameter int NUM_LD = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           sel,
  input  logic                 en_wr,
  input  logic                 hi_wr,
  input  logic                 lo_wr,
  input  logic [7:0]           wdata,
  output logic                 sel_valid,
  output logic                 sel_en,
  output logic [15:0]          sel_base,
  output logic [NUM_LD-1:0]    ld_enable,
  output logic [NUM_LD*16-1:0] ld_base
);
  localparam logic [8:0] LD_LIMIT = 9'(NUM_LD);

  logic [NUM_LD-1:0] hit;
  logic [15:0]       base_q [NUM_LD];

  assign sel_valid = ({1'b0, sel} < LD_LIMIT);

  for (genvar g = 0; g < NUM_LD; g++) begin : g_dev
    logic        en_q, en_d;
    logic [15:0] base_d;

    assign hit[g] = sel_valid && (sel == 8'(g));

    always_comb begin
      en_d   = en_q;
      base_d = base_q[g];
      if (hit[g] && en_wr) en_d = wdata[0];
      if (hit[g] && hi_wr) base_d[15:8] = wdata;
      if (hit[g] && lo_wr) base_d[7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q      <= 1'b0;
        base_q[g] <= 16'h0000;
      end else begin
        en_q      <= en_d;
        base_q[g] <= base_d;
      end
    end

    assign ld_enable[g]         = en_q;
    assign ld_base[g*16 +: 16]  = base_q[g];
  end

  always_comb begin
    sel_en   = 1'b0;
    sel_base = 16'h0000;
    for (int i = 0; i < NUM_LD; i++) begin
      sel_en   = sel_en | (hit[i] & ld_enable[i]);
      sel_base = sel_base | ({16{hit[i]}} & base_q[i]);
    end
  end
endmodule

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID = 16'h0A51,
  parameter logic [7:0]  REVISION  = 8'h01,
  parameter logic [15:0] MFG_ID    = 16'h1934
) (
  input  logic        cfg_open,
  input  logic        host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  index,
  input  logic [7:0]  ld_sel,
  input  logic        sel_valid,
  input  logic        sel_en,
  input  logic [15:0] sel_base,
  input  logic [7:0]  dev_rdata,
  output bank_wr_t    bank_wr,
  output logic        dev_wr,
  output logic        dev_rd,
  output logic [7:0]  host_rdata
);
  logic data_wr, data_rd, in_bank, bank_local, bank_ok;

  assign data_wr    = cfg_open && host_wr && host_addr;
  assign data_rd    = cfg_open && host_rd && host_addr;
  assign in_bank    = (index >= IDX_BANK_BASE);
  assign bank_local = (index == IDX_LD_ENABLE) || (index == IDX_IOBASE_HI) ||
                      (index == IDX_IOBASE_LO);
  assign bank_ok    = in_bank && sel_valid;

  assign bank_wr.sel_wr = data_wr && (index == IDX_LD_SELECT);
  assign bank_wr.en_wr  = data_wr && bank_ok && (index == IDX_LD_ENABLE);
  assign bank_wr.hi_wr  = data_wr && bank_ok && (index == IDX_IOBASE_HI);
  assign bank_wr.lo_wr  = data_wr && bank_ok && (index == IDX_IOBASE_LO);

  assign dev_wr = data_wr && bank_ok && !bank_local;
  assign dev_rd = data_rd && bank_ok && !bank_local;

  always_comb begin
    host_rdata = 8'hFF;
    if (cfg_open) begin
      if (!host_addr) begin
        host_rdata = index;
      end else if (in_bank) begin
        if (sel_valid) begin
          unique case (index)
            IDX_LD_ENABLE: host_rdata = {7'b0, sel_en};
            IDX_IOBASE_HI: host_rdata = sel_base[15:8];
            IDX_IOBASE_LO: host_rdata = sel_base[7:0];
            default:       host_rdata = dev_rdata;
          endcase
        end
      end else begin
        unique case (index)
          IDX_LD_SELECT: host_rdata = ld_sel;
          IDX_DEVID_HI:  host_rdata = DEVICE_ID[15:8];
          IDX_DEVID_LO:  host_rdata = DEVICE_ID[7:0];
          IDX_REVISION:  host_rdata = REVISION;
          IDX_MFG_HI:    host_rdata = MFG_ID[15:8];
          IDX_MFG_LO:    host_rdata = MFG_ID[7:0];
          default:       host_rdata = 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfg_port_pkg::*;
#(
  parameter int          NUM_LD     = 8,
  parameter logic [15:0] DEVICE_ID  = 16'h0A51,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic [15:0] MFG_ID     = 16'h1934,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic [NUM_LD-1:0]    ld_enable,
  output logic [NUM_LD*16-1:0] ld_base,
  output logic [7:0]           dev_ld,
  output logic [7:0]           dev_idx,
  output logic [7:0]           dev_wdata,
  output logic                 dev_wr,
  output logic                 dev_rd,
  input  logic [7:0]           dev_rdata
);
  logic        rst_sync_n;
  logic        cfg_open, idx_ld;
  logic [7:0]  index_q, index_d;
  logic [7:0]  ld_sel_q, ld_sel_d;
  logic        sel_valid, sel_en;
  logic [15:0] sel_base;
  bank_wr_t    bank_wr;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_key_seq #(
    .UNLOCK_KEY (UNLOCK_KEY),
    .LOCK_KEY   (LOCK_KEY)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_wr (host_wr && !host_addr),
    .wdata  (host_wdata),
    .open_o (cfg_open),
    .idx_ld (idx_ld)
  );

  always_comb begin
    index_d  = idx_ld ? host_wdata : index_q;
    ld_sel_d = bank_wr.sel_wr ? host_wdata : ld_sel_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      index_q  <= 8'h00;
      ld_sel_q <= 8'h00;
    end else begin
      index_q  <= index_d;
      ld_sel_q <= ld_sel_d;
    end
  end

  cfg_ld_bank #(.NUM_LD(NUM_LD)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (ld_sel_q),
    .en_wr     (bank_wr.en_wr),
    .hi_wr     (bank_wr.hi_wr),
    .lo_wr     (bank_wr.lo_wr),
    .wdata     (host_wdata),
    .sel_valid (sel_valid),
    .sel_en    (sel_en),
    .sel_base  (sel_base),
    .ld_enable (ld_enable),
    .ld_base   (ld_base)
  );

  cfg_reg_decode #(
    .DEVICE_ID (DEVICE_ID),
    .REVISION  (REVISION),
    .MFG_ID    (MFG_ID)
  ) u_dec (
    .cfg_open   (cfg_open),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .index      (index_q),
    .ld_sel     (ld_sel_q),
    .sel_valid  (sel_valid),
    .sel_en     (sel_en),
    .sel_base   (sel_base),
    .dev_rdata  (dev_rdata),
    .bank_wr    (bank_wr),
    .dev_wr     (dev_wr),
    .dev_rd     (dev_rd),
    .host_rdata (host_rdata)
  );

  assign dev_ld    = ld_sel_q;
  assign dev_idx   = index_q;
  assign dev_wdata = host_wdata;
endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int          NUM_LD     = 8,
  parameter logic [15:0] MFG_ID     = 16'h1934,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 cfg_open,
  input logic [7:0]           index_q,
  input logic                 host_addr,
  input logic                 host_wr,
  input logic                 host_rd,
  input logic [7:0]           host_wdata,
  input logic [7:0]           host_rdata,
  input logic [NUM_LD-1:0]    ld_enable,
  input logic [NUM_LD*16-1:0] ld_base,
  input logic                 dev_wr,
  input logic                 dev_rd
);
  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_open && host_rd) |-> (host_rdata == 8'hFF)); // R4

  AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_open |-> (!dev_wr && !dev_rd)); // R4

  AST_LOCKED_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_open |=> ($stable(ld_enable) && $stable(ld_base))); // R4

  AST_LOCKED_INDEX_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_open |=> $stable(index_q)); // R4

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(cfg_open) |-> $past(host_wr && !host_addr && host_wdata == UNLOCK_KEY)); // R2

  AST_LOCK_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_open && host_wr && !host_addr && host_wdata == LOCK_KEY) |=> !cfg_open); // R5

  AST_MFG_HI_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_open && host_addr && index_q == 8'h23) |-> (host_rdata == MFG_ID[15:8])); // R7
endmodule

bind cfg_key_port cfg_key_port_chk #(
  .NUM_LD     (NUM_LD),
  .MFG_ID     (MFG_ID),
  .UNLOCK_KEY (UNLOCK_KEY),
  .LOCK_KEY   (LOCK_KEY)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_open   (cfg_open),
  .index_q    (index_q),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .ld_enable  (ld_enable),
  .ld_base    (ld_base),
  .dev_wr     (dev_wr),
  .dev_rd     (dev_rd)
);

// File: tb/tb_cfg_key_port.sv
module tb_cfg_key_port;
  localparam int CLK_P = 10;
  localparam int NLD   = 4;
  localparam logic [15:0] DEVID = 16'h0A51;
  localparam logic [7:0]  REV   = 8'h3C;

  logic clk = 1'b0;
  logic rst_n;
  logic host_addr, host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic [NLD-1:0] ld_enable;
  logic [NLD*16-1:0] ld_base;
  logic [7:0] dev_ld, dev_idx, dev_wdata, dev_rdata;
  logic dev_wr, dev_rd;

  always #(CLK_P/2) clk = ~clk;
  assign dev_rdata = dev_idx ^ 8'h5A ^ dev_ld;

  cfg_key_port #(.NUM_LD(NLD), .DEVICE_ID(DEVID), .REVISION(REV)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ld_enable(ld_enable), .ld_base(ld_base), .dev_ld(dev_ld), .dev_idx(dev_idx),
    .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_unl = 0, m_arm = 0;
  int m_idx = 0, m_sel = 0;
  int m_en [NLD];
  int m_base [NLD];
  int last_rd, s_idx, s_ld, s_wd, s_wr;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_local(int i);
    return (i == 'h30) || (i == 'h60) || (i == 'h61);
  endfunction

  function automatic int model_read(logic a);
    if (!m_unl) return 'hFF;
    if (!a) return m_idx;
    if (m_idx >= 'h30) begin
      if (m_sel >= NLD) return 'hFF;
      if (m_idx == 'h30) return m_en[m_sel];
      if (m_idx == 'h60) return m_base[m_sel] >> 8;
      if (m_idx == 'h61) return m_base[m_sel] & 'hFF;
      return (m_idx ^ 'h5A ^ m_sel) & 'hFF;
    end
    case (m_idx)
      'h07: return m_sel;
      'h20: return DEVID >> 8;
      'h21: return DEVID & 'hFF;
      'h22: return REV;
      'h23: return 'h19;
      'h24: return 'h34;
      default: return 'hFF;
    endcase
  endfunction

  function automatic bit model_strobe(logic a, logic s);
    return m_unl && s && a && (m_idx >= 'h30) && !is_local(m_idx) && (m_sel < NLD);
  endfunction

  task automatic model_write(logic a, logic w, int d);
    if (!w) return;
    if (!a) begin
      if (!m_unl) begin
        if (m_arm) begin m_unl = (d == 'h87); m_arm = 0; end
        else m_arm = (d == 'h87);
      end else if (d == 'hAA) m_unl = 0;
      else m_idx = d;
    end else if (m_unl) begin
      if (m_idx == 'h07) m_sel = d;
      else if (m_sel < NLD && m_idx == 'h30) m_en[m_sel] = d & 1;
      else if (m_sel < NLD && m_idx == 'h60) m_base[m_sel] = (m_base[m_sel] & 'hFF) | (d << 8);
      else if (m_sel < NLD && m_idx == 'h61) m_base[m_sel] = (m_base[m_sel] & 'hFF00) | d;
    end
  endtask

  task automatic step(input logic a, input logic w, input logic r,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    #(CLK_P/2 - 1);
    if (r) chk(tag, host_rdata, model_read(a));
    last_rd = host_rdata;
    chk("R11 dev_wr", dev_wr, model_strobe(a, w));
    chk("R11 dev_rd", dev_rd, model_strobe(a, r));
    s_idx = dev_idx; s_ld = dev_ld; s_wd = dev_wdata; s_wr = dev_wr;
    @(posedge clk);
    model_write(a, w, d);
    #1;
    for (int i = 0; i < NLD; i++) begin
      chk("R9 ld_enable", ld_enable[i], m_en[i]);
      chk("R10 ld_base", ld_base[i*16 +: 16], m_base[i]);
    end
    host_wr = 0; host_rd = 0;
  endtask

  task automatic iw(input logic [7:0] d, input string t); step(0, 1, 0, d, t); endtask
  task automatic dw(input logic [7:0] d, input string t); step(1, 1, 0, d, t); endtask
  task automatic dr(input string t); step(1, 0, 1, 8'h00, t); endtask
  task automatic ir(input string t); step(0, 0, 1, 8'h00, t); endtask
  task automatic unlock(); iw(8'h87, "R2"); iw(8'h87, "R2"); endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < NLD; i++) begin m_en[i] = 0; m_base[i] = 0; end
    rst_n = 0; host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enables", ld_enable, 0);
    chk("R1 bases", ld_base == '0, 1);
    dr("R1 locked read");
    chk("R1 locked read FF", last_rd, 'hFF);
    // R4 locked accesses ignored
    iw(8'h07, "R4");
    dw(8'h03, "R4");
    ir("R4 index read locked");
    chk("R4 index port FF", last_rd, 'hFF);
    // R3 interrupted sequence
    iw(8'h87, "R3"); iw(8'h55, "R3"); iw(8'h87, "R3");
    dr("R3 still locked");
    chk("R3 locked after break", last_rd, 'hFF);
    iw(8'h87, "R3");
    ir("R1 index after reset");
    chk("R1 index zero", last_rd, 'h00);
    iw(8'h07, "R6"); dr("R1 select zero");
    chk("R1 select zero", last_rd, 'h00);
    // R7 identification
    iw(8'h20, "R7"); dr("R7 devid hi"); chk("R7 devid hi", last_rd, 'h0A);
    iw(8'h21, "R7"); dr("R7 devid lo");
    iw(8'h22, "R7"); dr("R7 rev"); chk("R7 rev", last_rd, 'h3C);
    iw(8'h23, "R7"); dw(8'h00, "R7"); dr("R7 mfg hi"); chk("R7 mfg hi", last_rd, 'h19);
    iw(8'h24, "R7"); dr("R7 mfg lo"); chk("R7 mfg lo", last_rd, 'h34);
    // R8 R9 R10 banks
    iw(8'h07, "R8"); dw(8'h02, "R8"); dr("R8 select");
    iw(8'h30, "R9"); dw(8'hFF, "R9"); dr("R9 enable");
    chk("R9 enable bit2", ld_enable, 4'b0100);
    iw(8'h60, "R10"); dw(8'h12, "R10");
    iw(8'h61, "R10"); dw(8'h34, "R10"); dr("R10 base lo");
    iw(8'h07, "R8"); dw(8'h01, "R8");
    iw(8'h60, "R10"); dw(8'hBE, "R10");
    iw(8'h61, "R10"); dw(8'hEF, "R10");
    chk("R10 base dev1", ld_base[31:16], 'hBEEF);
    chk("R10 base dev2", ld_base[47:32], 'h1234);
    iw(8'h07, "R8"); dw(8'h02, "R8");
    iw(8'h60, "R10"); dr("R8 bank2 base hi"); chk("R8 bank isolation", last_rd, 'h12);
    // R11 forwarding
    iw(8'h07, "R11"); dw(8'h03, "R11");
    iw(8'hF0, "R11"); dw(8'h77, "R11");
    chk("R11 strobe", s_wr, 1);
    chk("R11 dev_idx", s_idx, 'hF0);
    chk("R11 dev_ld", s_ld, 'h03);
    chk("R11 dev_wdata", s_wd, 'h77);
    iw(8'hF5, "R11"); dr("R11 device read");
    chk("R11 device read", last_rd, 'hF5 ^ 'h5A ^ 'h03);
    // R12 out-of-range select
    iw(8'h07, "R12"); dw(8'h05, "R12");
    iw(8'h30, "R12"); dw(8'h01, "R12"); dr("R12 bank read");
    chk("R12 bank FF", last_rd, 'hFF);
    iw(8'h45, "R12"); dw(8'h11, "R12"); dr("R12 no strobe");
    // R13 unimplemented globals
    iw(8'h2B, "R13"); dw(8'h00, "R13"); dr("R13 unimpl"); chk("R13 unimpl FF", last_rd, 'hFF);
    iw(8'h10, "R13"); dr("R13 low index");
    // R5 relock keeps index
    iw(8'h07, "R5"); dw(8'h02, "R5"); iw(8'h30, "R5");
    iw(8'hAA, "R5");
    dw(8'h00, "R4 locked write"); dr("R5 locked");
    chk("R5 relocked", last_rd, 'hFF);
    chk("R4 enable kept", ld_enable, 4'b0100);
    unlock();
    ir("R5 index kept"); chk("R5 index kept", last_rd, 'h30);
    dr("R9 enable kept");
    // R6 index port writes of unlock key while open load index
    iw(8'h87, "R6"); ir("R6 index load"); chk("R6 index 87", last_rd, 'h87);
    summary();
  end
endmodule